// File: doc/BRIEF.md
# Transmitter Credit Gating Unit

This block sits on the transmit side of a packet link. It holds six credit counters that mirror the free entries in the far-end receiver's buffers: one command counter and one data counter for each of three virtual channels (posted request, non-posted request, response). A requester presents a packet per channel together with a flag that says whether the packet carries data. The block grants the send in the same cycle only when the credits that packet needs are present. On the clock edge that ends the grant cycle it consumes those credits.

Credits come back only through NOP update fields. When a NOP arrives (strobe high), each 2-bit field is added to its counter. A field of zero changes nothing. A grant and a returned credit on the same counter in the same cycle are merged into one net update. Every counter saturates at its configured maximum.

Each channel has a two-state gate machine. GATE_IDLE moves to GATE_STALL when a request is present but lacks credits. GATE_STALL moves back to GATE_IDLE once the request is granted or withdrawn. A link machine starts in LNK_INIT and moves to LNK_RUN on the first NOP that reports a non-zero credit field. It stays in LNK_RUN until reset.

Top module: `credit_gate`

## Requirements
- R1: After reset every counter reads zero, and no request is granted until a NOP has returned credits.
- R2: A request without data on channel v is granted in the same cycle if and only if the command counter of v is non-zero.
- R3: A request with data on channel v is granted only if both the command counter and the data counter of v are non-zero; otherwise it stalls.
- R4: On a grant, the command counter of v drops by one in the next cycle, and the data counter of v also drops by one when the packet carries data.
- R5: When nop_vld is high, each 2-bit field of nop_credit is added to its counter. Field k occupies bits [2k+1:2k], with k = 2*v + d, where d=0 is command and d=1 is data, and v=0 posted, v=1 non-posted, v=2 response. A zero field leaves its counter unchanged. When nop_vld is low, nop_credit has no effect.
- R6: A grant and a non-zero NOP field on the same counter in the same cycle give a single net change of (field - 1).
- R7: A counter never exceeds its maximum (CMD_MAX for command counters, DATA_MAX for data counters), and an update that would pass the maximum leaves the counter at the maximum.
- R8: The channels are independent. A stalled channel does not block a grant on another channel that has credits.
- R9: stall[v] is high exactly when req_vld[v] is high and grant[v] is low. A stalled request is held, with the same data flag, until it is granted.
- R10: While the link machine is in LNK_INIT, no grant is issued. It enters LNK_RUN on the first valid NOP with a non-zero field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 3 | Send request per channel (bit v = channel v) |
| req_data | input | 3 | Request carries data, per channel |
| nop_vld | input | 1 | Incoming NOP credit fields valid |
| nop_credit | input | 12 | Six 2-bit credit-return fields, layout as in R5 |
| grant | output | 3 | Send granted this cycle, per channel |
| stall | output | 3 | Request present but lacking credits, per channel |
| credit_cnt | output | 6*CW | Counter k in bits [k*CW +: CW], CW = $clog2(max(CMD_MAX,DATA_MAX)+1) |

## Verification
The hold check in the gate machine assumes a well-behaved requester: once a channel stalls, its request stays up and its data flag does not change until the grant. The bench keeps one pending packet per channel and re-presents it, unchanged, every cycle until the reference model reports a grant. The counter assertions assume that a consume only ever reaches a non-zero counter, and the grant logic is what guarantees this. NOP fields are driven freely, including with the strobe low, because the block must ignore them then.

// File: rtl/cg_pkg.sv
package cg_pkg;
    localparam int NUM_VC  = 3;
    localparam int NUM_BUF = 2 * NUM_VC;
    localparam int NOP_FW  = 2;

    typedef enum logic [1:0] {
        VC_POSTED    = 2'd0,
        VC_NONPOSTED = 2'd1,
        VC_RESPONSE  = 2'd2
    } vc_e;

    typedef enum logic {
        LNK_INIT = 1'b0,
        LNK_RUN  = 1'b1
    } lnk_state_e;

    typedef enum logic {
        GATE_IDLE  = 1'b0,
        GATE_STALL = 1'b1
    } gate_state_e;
endpackage

// File: rtl/cg_credit_ctr.sv
module cg_credit_ctr #(
    parameter int MAX = 7,
    parameter int CW  = 3,
    parameter int AW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] add,
    input  logic          take,
    output logic [CW-1:0] cnt
);
    localparam int SW = CW + AW + 1;

    logic [SW-1:0] sum;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        sum = SW'(cnt) + SW'(add) - SW'(take);
        if (sum > SW'(MAX))
            cnt_nxt = CW'(MAX);
        else
            cnt_nxt = sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= MAX);

    a_r4_take_only: assert property (@(posedge clk) disable iff (!rst_n)
        (take && add == '0) |=> int'(cnt) == int'($past(cnt)) - 1);

    a_r5_add_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && add != '0 && int'(cnt) + int'(add) <= MAX)
        |=> int'(cnt) == int'($past(cnt)) + int'($past(add)));

    a_r6_net_update: assert property (@(posedge clk) disable iff (!rst_n)
        (take && add != '0 && int'(cnt) + int'(add) - 1 <= MAX)
        |=> int'(cnt) == int'($past(cnt)) + int'($past(add)) - 1);

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) + int'(add) - int'(take) > MAX) |=> int'(cnt) == MAX);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt != '0);
endmodule

// File: rtl/cg_vc_gate.sv
module cg_vc_gate #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_data,
    input  logic [CW-1:0] cmd_cnt,
    input  logic [CW-1:0] dat_cnt,
    output logic          grant,
    output logic          stall,
    output logic          take_cmd,
    output logic          take_dat
);
    import cg_pkg::*;

    gate_state_e state, state_nxt;
    logic        credits_ok;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= GATE_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        credits_ok = (cmd_cnt != '0) && (!req_data || dat_cnt != '0);
        state_nxt  = state;
        unique case (state)
            GATE_IDLE:  if (req && !credits_ok) state_nxt = GATE_STALL;
            GATE_STALL: if (!req || credits_ok) state_nxt = GATE_IDLE;
            default:    state_nxt = GATE_IDLE;
        endcase
    end

    always_comb begin
        grant    = req && credits_ok;
        stall    = req && !credits_ok;
        take_cmd = grant;
        take_dat = grant && req_data;
    end

    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_STALL) |-> (req && $stable(req_data)));

    a_r9_grant_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall));
endmodule

// File: rtl/credit_gate.sv
module credit_gate #(
    parameter int CMD_MAX  = 7,
    parameter int DATA_MAX = 7,
    localparam int TOP_MAX = (CMD_MAX > DATA_MAX) ? CMD_MAX : DATA_MAX,
    localparam int CW      = $clog2(TOP_MAX + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [cg_pkg::NUM_VC-1:0]          req_vld,
    input  logic [cg_pkg::NUM_VC-1:0]          req_data,
    input  logic                               nop_vld,
    input  logic [cg_pkg::NUM_BUF*cg_pkg::NOP_FW-1:0] nop_credit,
    output logic [cg_pkg::NUM_VC-1:0]          grant,
    output logic [cg_pkg::NUM_VC-1:0]          stall,
    output logic [cg_pkg::NUM_BUF*CW-1:0]      credit_cnt
);
    import cg_pkg::*;

    logic [CW-1:0]     cnt_arr  [NUM_BUF];
    logic [NOP_FW-1:0] add_arr  [NUM_BUF];
    logic              take_arr [NUM_BUF];
    lnk_state_e        lnk_state, lnk_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lnk_state <= LNK_INIT;
        else
            lnk_state <= lnk_nxt;
    end

    always_comb begin
        lnk_nxt = lnk_state;
        unique case (lnk_state)
            LNK_INIT: if (nop_vld && (|nop_credit)) lnk_nxt = LNK_RUN;
            LNK_RUN:  lnk_nxt = LNK_RUN;
            default:  lnk_nxt = LNK_INIT;
        endcase
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BUF; b++) begin : g_buf
            localparam int BMAX = (b % 2 == 1) ? DATA_MAX : CMD_MAX;

            always_comb
                add_arr[b] = nop_vld ? nop_credit[b*NOP_FW +: NOP_FW] : '0;

            cg_credit_ctr #(.MAX(BMAX), .CW(CW), .AW(NOP_FW)) u_ctr (
                .clk  (clk),
                .rst_n(rst_n),
                .add  (add_arr[b]),
                .take (take_arr[b]),
                .cnt  (cnt_arr[b])
            );

            assign credit_cnt[b*CW +: CW] = cnt_arr[b];
        end
    endgenerate

    genvar v;
    generate
        for (v = 0; v < NUM_VC; v++) begin : g_vc
            cg_vc_gate #(.CW(CW)) u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (req_vld[v]),
                .req_data(req_data[v]),
                .cmd_cnt (cnt_arr[2*v]),
                .dat_cnt (cnt_arr[2*v+1]),
                .grant   (grant[v]),
                .stall   (stall[v]),
                .take_cmd(take_arr[2*v]),
                .take_dat(take_arr[2*v+1])
            );

            a_r2_grant_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
                grant[v] |-> cnt_arr[2*v] != '0);

            a_r3_grant_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[v] && req_data[v]) |-> cnt_arr[2*v+1] != '0);

            a_r9_stall_is_unserved: assert property (@(posedge clk) disable iff (!rst_n)
                stall[v] == (req_vld[v] && !grant[v]));
        end
    endgenerate

    a_r10_no_grant_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_state == LNK_INIT) |-> grant == '0);

    a_r10_init_counters_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_state == LNK_INIT) |-> credit_cnt == '0);
endmodule

// File: tb/test_credit_gate.sv
module test_credit_gate;
    localparam int NVC  = 3;
    localparam int NB   = 6;
    localparam int CMAX = 7;
    localparam int DMAX = 7;
    localparam int CW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NVC-1:0]  req_vld = '0;
    logic [NVC-1:0]  req_data = '0;
    logic            nop_vld = 1'b0;
    logic [2*NB-1:0] nop_credit = '0;
    logic [NVC-1:0]  grant;
    logic [NVC-1:0]  stall;
    logic [NB*CW-1:0] credit_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_cnt [NB];
    bit pend  [NVC];
    bit pdat  [NVC];

    always #4 clk = ~clk;

    credit_gate #(.CMD_MAX(CMAX), .DATA_MAX(DMAX)) i_credit_gate (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_data(req_data),
        .nop_vld(nop_vld), .nop_credit(nop_credit),
        .grant(grant), .stall(stall), .credit_cnt(credit_cnt)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic check_counters(input string tag);
        for (int b = 0; b < NB; b++)
            chk(int'(credit_cnt[b*CW +: CW]), m_cnt[b],
                $sformatf("%s counter %0d", tag, b));
    endtask

    // one cycle: called at negedge; compares, drives, advances model
    task automatic step(input bit nv, input logic [2*NB-1:0] nc);
        bit g [NVC];
        int nxt;
        int add;
        int take;
        check_counters("R4 R5 R6 R7");
        for (int v = 0; v < NVC; v++) begin
            req_vld[v]  = pend[v];
            req_data[v] = pdat[v];
        end
        nop_vld    = nv;
        nop_credit = nc;
        #1;
        for (int v = 0; v < NVC; v++) begin
            g[v] = pend[v] && m_cnt[2*v] > 0 && (!pdat[v] || m_cnt[2*v+1] > 0);
            chk(int'(grant[v]), int'(g[v]),
                $sformatf("R2 R3 R8 grant vc%0d data=%0d", v, pdat[v]));
            chk(int'(stall[v]), int'(pend[v] && !g[v]),
                $sformatf("R9 stall vc%0d", v));
        end
        @(posedge clk);
        for (int b = 0; b < NB; b++) begin
            add  = nv ? int'(nc[2*b +: 2]) : 0;
            take = (b % 2 == 0) ? int'(g[b/2]) : int'(g[b/2] && pdat[b/2]);
            nxt  = m_cnt[b] + add - take;
            if (nxt > ((b % 2 == 1) ? DMAX : CMAX))
                nxt = (b % 2 == 1) ? DMAX : CMAX;
            m_cnt[b] = nxt;
        end
        for (int v = 0; v < NVC; v++)
            if (g[v]) pend[v] = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [2*NB-1:0] fld(input int b, input int val);
        logic [2*NB-1:0] r = '0;
        r[2*b +: 2] = 2'(val);
        return r;
    endfunction

    initial begin
        for (int b = 0; b < NB; b++) m_cnt[b] = 0;
        for (int v = 0; v < NVC; v++) begin pend[v] = 0; pdat[v] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_counters("R1 reset");
        chk(int'(grant), 0, "R1 reset grant");
        rst_n = 1'b1;

        // R1 R10: requests with no credits stall; NOP with strobe low ignored (R5)
        pend[0] = 1; pdat[0] = 0;
        pend[1] = 1; pdat[1] = 1;
        step(1'b0, '1);
        step(1'b0, '0);
        // R5: posted command field = 1 arrives; posted still stalls this cycle
        step(1'b1, fld(0, 1));
        // R2: posted command-only now granted, non-posted still stalled (R8)
        step(1'b0, '0);
        // R3: non-posted command credit only, data request keeps stalling
        step(1'b1, fld(2, 2));
        step(1'b0, '0);
        step(1'b1, fld(3, 1));
        step(1'b0, '0);
        // R6: grant and return on same counter in one cycle
        pend[2] = 1; pdat[2] = 0;
        step(1'b1, fld(4, 3));
        step(1'b1, fld(4, 2));
        step(1'b0, '0);
        // R7: saturate every counter
        for (int i = 0; i < 5; i++) step(1'b1, '1);
        // R8: drain posted, keep response flowing
        for (int i = 0; i < 10; i++) begin
            if (!pend[0]) begin pend[0] = 1; pdat[0] = 1; end
            if (!pend[2]) begin pend[2] = 1; pdat[2] = 1; end
            step(1'b0, '0);
        end

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            for (int v = 0; v < NVC; v++)
                if (!pend[v] && ($urandom % 3 == 0)) begin
                    pend[v] = 1;
                    pdat[v] = 1'($urandom % 2);
                end
            step(($urandom % 4) == 0, (2*NB)'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule